// File: doc/BRIEF.md
# Lock Elision Store Filter

This block sits between a core's retiring store path and the memory write interface. It intercepts lock stores that carry an acquire or release hint. A hinted acquire starts a speculative region. The block records the lock address, the value the atomic read (the prior value) and the value being written (the new value). It posts the lock address to the read-set tracker and withholds the write, so the lock never changes in memory and other agents keep seeing the prior value.

While the region is open, local loads to the lock address are answered from the saved new value, so the core behaves as if it holds the lock. All other loads go out to memory unchanged. A hinted release ends the region. If it targets the elided lock and writes back exactly the saved prior value, the write is dropped and the block requests a commit. Any other hinted release requests an abort.

An abort from the conflict tracker also ends the region with an abort request. After any abort the block enters a fallback state, in which every hint is ignored, until the next store with no hint retires. Only one lock is elided at a time.

Top module: `lel_store_filter`

## Requirements
- R1: A store with only the acquire hint, seen while no elision is active and fallback is low, produces no memory write. One cycle later `rset_valid` pulses with `rset_addr` equal to the store address, and `tx_active` rises.
- R2: While `tx_active` is high, a load whose address equals the elided lock address gives `fwd_hit`=1 with `fwd_data` equal to the acquire's store data, one cycle after the request. It issues no memory read.
- R3: A load to any other address, or any load while no elision is active, gives `mem_rd_valid`=1 with an unchanged address one cycle later, and `fwd_hit`=0.
- R4: A store with only the release hint, to the elided lock address and with data equal to the saved prior value, produces no memory write. One cycle later it pulses `commit_req` and clears `tx_active`.
- R5: A release-hinted store during elision whose data differs from the saved prior value, or whose address differs from the lock address, is dropped. One cycle later it pulses `abort_req`, clears `tx_active` and sets `fallback`.
- R6: `tx_abort_in` high while `tx_active` is high pulses `abort_req`, clears `tx_active` and sets `fallback` one cycle later. Afterwards, loads to the lock address go to memory.
- R7: While `fallback` is high, hinted stores are written to memory as plain stores, with no read-set entry, commit or abort. The first store with neither hint is also written, and it clears `fallback`.
- R8: An acquire-hinted store while an elision is active is written to memory as a plain store, with no read-set entry. The elided lock's forwarded value is unchanged.
- R9: A store with neither hint appears on `mem_wr_valid`/`mem_wr_addr`/`mem_wr_data` exactly one cycle later, with address and data unchanged.
- R10: After reset, every output is low.
- R11: A release-hinted store while no elision is active and fallback is low is written to memory as a plain store, without commit or abort.
- R12: A store with both hints set is treated as a plain store: it is written to memory and starts no elision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store retires this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data (new value) |
| st_old | input | DATA_W | Value the atomic read from the lock (prior value) |
| st_acq | input | 1 | Acquire hint |
| st_rel | input | 1 | Release hint |
| ld_valid | input | 1 | Load request |
| ld_addr | input | ADDR_W | Load address |
| tx_abort_in | input | 1 | Region cannot continue (from conflict tracker) |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_valid | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| fwd_hit | output | 1 | Load answered locally |
| fwd_data | output | DATA_W | Forwarded lock value |
| rset_valid | output | 1 | Read-set insertion strobe |
| rset_addr | output | ADDR_W | Read-set insertion address |
| commit_req | output | 1 | Commit request pulse |
| abort_req | output | 1 | Abort request pulse |
| tx_active | output | 1 | Elision in progress |
| fallback | output | 1 | Hints ignored until next unhinted store |

## Verification
A corrupted lock address or saved new value shows at the forward port on the very next load to the lock. A wrong saved prior value turns a correct release into an abort one cycle after the release. A stuck fallback or active flag shows within one store as a write that is missing or unexpected, or as a missing read-set pulse. The bench sweeps every lock address against every load address in a small configuration, and cycles through the release outcomes. Each mistake therefore surfaces within one or two cycles of the operation that exposes it.

// File: rtl/lel_pkg.sv
package lel_pkg;

   typedef enum logic [2:0] {
      SK_NONE,
      SK_PLAIN,
      SK_ELIDE_ACQ,
      SK_COMMIT_REL,
      SK_ABORT_REL
   } st_kind_e;

endpackage

// File: rtl/lel_store_decode.sv
module lel_store_decode
   import lel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              st_acq,
   input  logic              st_rel,
   input  logic              tx_abort_in,
   input  logic              active,
   input  logic              fallback,
   input  logic [ADDR_W-1:0] lock_addr,
   input  logic [DATA_W-1:0] lock_prior,
   output st_kind_e          kind,
   output logic              ext_abort
);

   logic act_eff;
   logic fb_eff;
   logic hint_acq;
   logic hint_rel;
   logic rel_match;

   always_comb begin
      ext_abort = active & tx_abort_in;
      act_eff   = active & ~tx_abort_in;
      fb_eff    = fallback | ext_abort;
      hint_acq  = st_acq & ~st_rel & ~fb_eff;
      hint_rel  = st_rel & ~st_acq & ~fb_eff;
      rel_match = (st_addr == lock_addr) && (st_data == lock_prior);
      if (!st_valid)
         kind = SK_NONE;
      else if (hint_acq && !act_eff)
         kind = SK_ELIDE_ACQ;
      else if (hint_rel && act_eff)
         kind = rel_match ? SK_COMMIT_REL : SK_ABORT_REL;
      else
         kind = SK_PLAIN;
   end

endmodule

// File: rtl/lel_lock_state.sv
module lel_lock_state
   import lel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  st_kind_e          kind,
   input  logic              ext_abort,
   input  logic              st_acq,
   input  logic              st_rel,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] st_old,
   output logic              active,
   output logic              fallback,
   output logic [ADDR_W-1:0] lock_addr,
   output logic [DATA_W-1:0] lock_new,
   output logic [DATA_W-1:0] lock_prior
);

   logic fb_set;
   logic fb_clr;

   always_comb begin
      fb_set = (kind == SK_ABORT_REL) || ext_abort;
      fb_clr = fallback && (kind == SK_PLAIN) && !st_acq && !st_rel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         fallback   <= 1'b0;
         lock_addr  <= '0;
         lock_new   <= '0;
         lock_prior <= '0;
      end else begin
         if (kind == SK_ELIDE_ACQ) begin
            active     <= 1'b1;
            lock_addr  <= st_addr;
            lock_new   <= st_data;
            lock_prior <= st_old;
         end else if (kind == SK_COMMIT_REL || fb_set) begin
            active <= 1'b0;
         end
         if (fb_set)
            fallback <= 1'b1;
         else if (fb_clr)
            fallback <= 1'b0;
      end
   end

endmodule

// File: rtl/lel_store_out.sv
module lel_store_out
   import lel_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  st_kind_e          kind,
   input  logic              ext_abort,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              rset_valid,
   output logic [ADDR_W-1:0] rset_addr,
   output logic              commit_req,
   output logic              abort_req
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_wr_valid <= 1'b0;
         rset_valid   <= 1'b0;
         commit_req   <= 1'b0;
         abort_req    <= 1'b0;
      end else begin
         mem_wr_valid <= (kind == SK_PLAIN);
         rset_valid   <= (kind == SK_ELIDE_ACQ);
         commit_req   <= (kind == SK_COMMIT_REL);
         abort_req    <= (kind == SK_ABORT_REL) || ext_abort;
      end
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_wr_addr <= '0;
               mem_wr_data <= '0;
               rset_addr   <= '0;
            end else begin
               if (kind == SK_PLAIN) begin
                  mem_wr_addr <= st_addr;
                  mem_wr_data <= st_data;
               end
               if (kind == SK_ELIDE_ACQ)
                  rset_addr <= st_addr;
            end
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (kind == SK_PLAIN) begin
               mem_wr_addr <= st_addr;
               mem_wr_data <= st_data;
            end
            if (kind == SK_ELIDE_ACQ)
               rset_addr <= st_addr;
         end
      end
   endgenerate

endmodule

// File: rtl/lel_load_fwd.sv
module lel_load_fwd #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              active,
   input  logic [ADDR_W-1:0] lock_addr,
   input  logic [DATA_W-1:0] lock_new,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic              fwd_hit,
   output logic [DATA_W-1:0] fwd_data
);

   logic hit;

   always_comb hit = ld_valid && active && (ld_addr == lock_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_valid <= 1'b0;
         mem_rd_addr  <= '0;
         fwd_hit      <= 1'b0;
         fwd_data     <= '0;
      end else begin
         mem_rd_valid <= ld_valid && !hit;
         fwd_hit      <= hit;
         if (ld_valid && !hit)
            mem_rd_addr <= ld_addr;
         if (hit)
            fwd_data <= lock_new;
      end
   end

endmodule

// File: rtl/lel_store_filter.sv
module lel_store_filter
   import lel_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] st_old,
   input  logic              st_acq,
   input  logic              st_rel,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              tx_abort_in,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic              fwd_hit,
   output logic [DATA_W-1:0] fwd_data,
   output logic              rset_valid,
   output logic [ADDR_W-1:0] rset_addr,
   output logic              commit_req,
   output logic              abort_req,
   output logic              tx_active,
   output logic              fallback
);

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("lel_store_filter: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 512) begin : g_bad_data
         $error("lel_store_filter: DATA_W out of range");
      end
   endgenerate

   st_kind_e          kind;
   logic              ext_abort;
   logic              active;
   logic              fb_q;
   logic [ADDR_W-1:0] lock_addr;
   logic [DATA_W-1:0] lock_new;
   logic [DATA_W-1:0] lock_prior;

   lel_store_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .st_valid   (st_valid),
      .st_addr    (st_addr),
      .st_data    (st_data),
      .st_acq     (st_acq),
      .st_rel     (st_rel),
      .tx_abort_in(tx_abort_in),
      .active     (active),
      .fallback   (fb_q),
      .lock_addr  (lock_addr),
      .lock_prior (lock_prior),
      .kind       (kind),
      .ext_abort  (ext_abort)
   );

   lel_lock_state #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .ext_abort (ext_abort),
      .st_acq    (st_acq),
      .st_rel    (st_rel),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .st_old    (st_old),
      .active    (active),
      .fallback  (fb_q),
      .lock_addr (lock_addr),
      .lock_new  (lock_new),
      .lock_prior(lock_prior)
   );

   lel_store_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind        (kind),
      .ext_abort   (ext_abort),
      .st_addr     (st_addr),
      .st_data     (st_data),
      .mem_wr_valid(mem_wr_valid),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data),
      .rset_valid  (rset_valid),
      .rset_addr   (rset_addr),
      .commit_req  (commit_req),
      .abort_req   (abort_req)
   );

   lel_load_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_valid    (ld_valid),
      .ld_addr     (ld_addr),
      .active      (active),
      .lock_addr   (lock_addr),
      .lock_new    (lock_new),
      .mem_rd_valid(mem_rd_valid),
      .mem_rd_addr (mem_rd_addr),
      .fwd_hit     (fwd_hit),
      .fwd_data    (fwd_data)
   );

   assign tx_active = active;
   assign fallback  = fb_q;

endmodule

// File: rtl/lel_checker.sv
module lel_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic [ADDR_W-1:0] st_addr,
   input logic [DATA_W-1:0] st_data,
   input logic              st_acq,
   input logic              st_rel,
   input logic              tx_abort_in,
   input logic              mem_wr_valid,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic              mem_rd_valid,
   input logic              fwd_hit,
   input logic              rset_valid,
   input logic [ADDR_W-1:0] rset_addr,
   input logic              commit_req,
   input logic              abort_req,
   input logic              tx_active,
   input logic              fallback
);

   p_acq_elided_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_valid && st_acq && !st_rel && !tx_active && !fallback && !tx_abort_in)
      |-> (rset_valid && !mem_wr_valid && tx_active && rset_addr == $past(st_addr)));

   p_fwd_or_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_hit && mem_rd_valid));

   p_commit_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> (!tx_active && !mem_wr_valid && !fallback));

   p_abort_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> (fallback && !tx_active && !commit_req));

   p_fallback_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fallback) |-> (!rset_valid && !commit_req));

   p_plain_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_valid && !st_acq && !st_rel)
      |-> (mem_wr_valid && mem_wr_data == $past(st_data)));

endmodule

bind lel_store_filter lel_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st_valid    (st_valid),
   .st_addr     (st_addr),
   .st_data     (st_data),
   .st_acq      (st_acq),
   .st_rel      (st_rel),
   .tx_abort_in (tx_abort_in),
   .mem_wr_valid(mem_wr_valid),
   .mem_wr_data (mem_wr_data),
   .mem_rd_valid(mem_rd_valid),
   .fwd_hit     (fwd_hit),
   .rset_valid  (rset_valid),
   .rset_addr   (rset_addr),
   .commit_req  (commit_req),
   .abort_req   (abort_req),
   .tx_active   (tx_active),
   .fallback    (fallback)
);

// File: tb/lel_store_filter_bench.sv
module lel_store_filter_bench;

   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [DW-1:0] st_old = '0;
   logic          st_acq = 1'b0;
   logic          st_rel = 1'b0;
   logic          ld_valid = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          tx_abort_in = 1'b0;
   logic          mem_wr_valid;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          mem_rd_valid;
   logic [AW-1:0] mem_rd_addr;
   logic          fwd_hit;
   logic [DW-1:0] fwd_data;
   logic          rset_valid;
   logic [AW-1:0] rset_addr;
   logic          commit_req;
   logic          abort_req;
   logic          tx_active;
   logic          fallback;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   lel_store_filter #(.ADDR_W(AW), .DATA_W(DW)) u_lel_store_filter (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_old(st_old),
      .st_acq(st_acq), .st_rel(st_rel),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .tx_abort_in(tx_abort_in),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .fwd_hit(fwd_hit), .fwd_data(fwd_data),
      .rset_valid(rset_valid), .rset_addr(rset_addr),
      .commit_req(commit_req), .abort_req(abort_req),
      .tx_active(tx_active), .fallback(fallback)
   );

   task automatic check(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_store(input int a, input int d, input int o, input bit acq, input bit rel);
      st_valid = 1'b1;
      st_addr  = AW'(a);
      st_data  = DW'(d);
      st_old   = DW'(o);
      st_acq   = acq;
      st_rel   = rel;
      @(negedge clk);
      st_valid = 1'b0;
      st_acq   = 1'b0;
      st_rel   = 1'b0;
   endtask

   task automatic do_load(input int a);
      ld_valid = 1'b1;
      ld_addr  = AW'(a);
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic plain_clear(input string req);
      do_store(0, 8'h3C, 0, 1'b0, 1'b0);
      check(int'(mem_wr_valid), 1, {req, " clearing store written"});
      check(int'(fallback), 0, {req, " fallback cleared"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(int'({mem_wr_valid, mem_rd_valid, fwd_hit, rset_valid}), 0, "R10 strobes");
      check(int'({commit_req, abort_req, tx_active, fallback}), 0, "R10 status");

      // R9 plain stores across every address
      for (int a = 0; a < 16; a++) begin
         do_store(a, (a * 7 + 3) & 8'hFF, 0, 1'b0, 1'b0);
         check(int'(mem_wr_valid), 1, "R9 valid");
         check(int'(mem_wr_addr), a, "R9 addr");
         check(int'(mem_wr_data), (a * 7 + 3) & 8'hFF, "R9 data");
         check(int'(rset_valid), 0, "R9 no rset");
      end

      // sweep every lock address
      for (int l = 0; l < 16; l++) begin
         do_store(l, 8'hA0 | l, l, 1'b1, 1'b0);
         check(int'(rset_valid), 1, "R1 rset pulse");
         check(int'(rset_addr), l, "R1 rset addr");
         check(int'(mem_wr_valid), 0, "R1 write withheld");
         check(int'(tx_active), 1, "R1 active");
         for (int a = 0; a < 16; a++) begin
            do_load(a);
            if (a == l) begin
               check(int'(fwd_hit), 1, "R2 hit");
               check(int'(fwd_data), 8'hA0 | l, "R2 data");
               check(int'(mem_rd_valid), 0, "R2 no mem read");
            end else begin
               check(int'(fwd_hit), 0, "R3 no hit");
               check(int'(mem_rd_valid), 1, "R3 mem read");
               check(int'(mem_rd_addr), a, "R3 addr");
            end
         end
         if (l % 4 == 2) begin
            do_store((l + 1) % 16, 8'h11, 0, 1'b1, 1'b0);
            check(int'(mem_wr_valid), 1, "R8 second acquire written");
            check(int'(rset_valid), 0, "R8 no rset");
            do_load(l);
            check(int'(fwd_data), 8'hA0 | l, "R8 forward kept");
         end
         case (l % 3)
            0: begin
               do_store(l, l, 0, 1'b0, 1'b1);
               check(int'(commit_req), 1, "R4 commit");
               check(int'(mem_wr_valid), 0, "R4 write withheld");
               check(int'(tx_active), 0, "R4 closed");
               check(int'(abort_req), 0, "R4 no abort");
            end
            1: begin
               do_store(l, l ^ 8'h40, 0, 1'b0, 1'b1);
               check(int'(abort_req), 1, "R5 data mismatch abort");
               check(int'(mem_wr_valid), 0, "R5 dropped");
               check(int'(fallback), 1, "R5 fallback");
               do_store(l, 8'h55, 0, 1'b1, 1'b0);
               check(int'(mem_wr_valid), 1, "R7 acquire written");
               check(int'(rset_valid), 0, "R7 no rset");
               do_store(l, 8'h66, 0, 1'b0, 1'b1);
               check(int'(mem_wr_valid), 1, "R7 release written");
               check(int'(commit_req | abort_req), 0, "R7 no commit or abort");
               check(int'(fallback), 1, "R7 still fallback");
               plain_clear("R7");
            end
            default: begin
               do_store((l + 1) % 16, l, 0, 1'b0, 1'b1);
               check(int'(abort_req), 1, "R5 address mismatch abort");
               check(int'(tx_active), 0, "R5 closed");
               plain_clear("R7");
            end
         endcase
      end

      // R6 external abort
      do_store(5, 8'hC5, 8'h05, 1'b1, 1'b0);
      tx_abort_in = 1'b1;
      @(negedge clk);
      tx_abort_in = 1'b0;
      check(int'(abort_req), 1, "R6 abort");
      check(int'(fallback), 1, "R6 fallback");
      check(int'(tx_active), 0, "R6 closed");
      do_load(5);
      check(int'(fwd_hit), 0, "R6 no forward");
      check(int'(mem_rd_valid), 1, "R6 load to memory");
      plain_clear("R6");

      // R11 release with no elision
      do_store(3, 8'h07, 0, 1'b0, 1'b1);
      check(int'(mem_wr_valid), 1, "R11 written");
      check(int'(commit_req | abort_req), 0, "R11 no commit or abort");

      // R12 both hints
      do_store(3, 8'h09, 0, 1'b1, 1'b1);
      check(int'(mem_wr_valid), 1, "R12 written");
      check(int'(mem_wr_data), 8'h09, "R12 data");
      check(int'(rset_valid | tx_active), 0, "R12 no elision");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule